// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block drives the fixed DDR2 power-up command sequence onto a small command interface once the memory clock is stable. A one-cycle start pulse begins the run. The block then issues every mode and extended-mode write, the precharge-all and the refresh burst in the order that DDR2 devices require. After that it waits out the calibration window and raises a sticky done flag. At that point the normal-traffic controller takes over the command bus.

Each command is a registered 3-bit code with a 2-bit bank select and a 14-bit address word, and it is present for exactly one clock. A NOP code fills every cycle between commands. The command spacing comes from parameters: a minimum mode-register gap, a precharge gap, a refresh cycle time and the calibration wait. The burst length, CAS latency, write recovery and additive latency fields are taken from input ports. These inputs must be held stable while the sequence runs.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is asserted, and after reset until start, the outputs are cmd_o = 0 (NOP), bank_o = 0, addr_o = 0 and done_o = 0. Reset acts asynchronously and also aborts a running sequence.
- R2: The commands come in this order: EMRS to EMR(2), EMRS to EMR(3), EMRS to EMR(1), MRS with DLL reset, precharge-all, N_REF refreshes, MRS with DLL reset cleared, then EMRS to EMR(1) to leave calibration. The codes are NOP=0, MRS=1, EMRS=2, PREA=3, REF=4.
- R3: EMRS commands select their target with bank_o: 1 is EMR(1), 2 is EMR(2) and 3 is EMR(3). The EMR(2) and EMR(3) writes carry addr_o = 0.
- R4: Both EMR(1) writes carry A0=0 (DLL enabled), A1=0, A2=A6=0 (termination off), A[5:3]=add_lat_i, A[9:7]=000 (calibration fields zero), A10=1 (complementary strobe disabled), and A11=A12=0 (read strobe off, outputs on).
- R5: MRS uses bank_o = 0 and an address word with A[2:0]=burst_len_i, A3=0, A[6:4]=cas_lat_i, A7=0, A[11:9]=wr_rec_i and A12=A13=0. A8 is 1 on the first MRS and 0 on the second. CAS latency is the same in both.
- R6: Precharge-all carries addr_o = 0x400 (A10 high) and bank_o = 0.
- R7: Exactly N_REF refreshes (N_REF at least 2) are issued, each with addr_o = 0 and bank_o = 0.
- R8: Each command lasts one cycle. The next command follows T_RP cycles after precharge-all, T_RFC cycles after each refresh, T_OCD cycles after the second MRS, and T_MRD cycles after any other command.
- R9: done_o rises T_MRD cycles after the final EMR(1) write. It then stays high until reset, and no further command is issued.
- R10: A start pulse that arrives while the sequence runs, or after done, has no effect on the command stream or on done_o.
- R11: The first command appears on the outputs in the cycle after the clock edge that samples start_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, used only when idle |
| burst_len_i | input | 3 | Burst length field for the mode register |
| cas_lat_i | input | 3 | CAS latency field for the mode register |
| wr_rec_i | input | 3 | Write recovery field for the mode register |
| add_lat_i | input | 3 | Additive latency field for EMR(1) |
| cmd_o | output | 3 | Command code (0 NOP, 1 MRS, 2 EMRS, 3 PREA, 4 REF) |
| bank_o | output | 2 | Bank select, which picks the EMR target on EMRS |
| addr_o | output | 14 | Mode or address word |
| done_o | output | 1 | Sequence complete, sticky until reset |

## Verification
A wrong step index shows at the ports as a missing, repeated or reordered command, or a wrong bank or address word. It appears on the first command issued after the fault. A timer fault shifts the cycle in which the next command appears, or keeps a command code asserted for longer than one clock. Both effects show up within one gap length. The bench records every command together with its cycle number and compares the stream with the expected ordered list and gap lengths. This catches a slip at the step where it happens, and a sticky-done fault shows at the first cycle after completion.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  localparam int ADDR_W = 14;

  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_MRS  = 3'd1,
    CMD_EMRS = 3'd2,
    CMD_PREA = 3'd3,
    CMD_REF  = 3'd4
  } cmd_e;

  typedef struct packed {
    cmd_e              code;
    logic [1:0]        bank;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_st_e;

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ddr2_init_gap_timer.sv
module ddr2_init_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [GAP_W-1:0] val_i,
  output logic             zero_o
);

  logic [GAP_W-1:0] cnt_q;

  // load with gap-1 so the next issue lands exactly val_i cycles later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i - GAP_W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - GAP_W'(1);
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr2_init_step_dec.sv
module ddr2_init_step_dec
  import ddr2_init_pkg::*;
#(
  parameter int N_REF  = 2,
  parameter int T_MRD  = 2,
  parameter int T_RP   = 3,
  parameter int T_RFC  = 14,
  parameter int T_OCD  = 200,
  parameter int STEP_W = 4,
  parameter int GAP_W  = 8
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [2:0]        burst_len_i,
  input  logic [2:0]        cas_lat_i,
  input  logic [2:0]        wr_rec_i,
  input  logic [2:0]        add_lat_i,
  output cmd_t              cmd_o,
  output logic [GAP_W-1:0]  gap_o
);

  localparam int S_EMR2    = 0;
  localparam int S_EMR3    = 1;
  localparam int S_EMR1_ON = 2;
  localparam int S_MR_RST  = 3;
  localparam int S_PREA    = 4;
  localparam int S_REF0    = 5;
  localparam int S_MR_RUN  = S_REF0 + N_REF;
  localparam int S_EMR1_X  = S_MR_RUN + 1;

  logic [ADDR_W-1:0] emr1_w;
  logic [ADDR_W-1:0] mr_w;
  int                s;

  always_comb begin
    emr1_w       = '0;
    emr1_w[5:3]  = add_lat_i;
    emr1_w[10]   = 1'b1;       // complementary strobe off
    mr_w         = '0;
    mr_w[2:0]    = burst_len_i;
    mr_w[6:4]    = cas_lat_i;
    mr_w[11:9]   = wr_rec_i;
  end

  always_comb begin
    s          = int'(step_i);
    cmd_o      = '{code: CMD_NOP, bank: 2'd0, addr: '0};
    gap_o      = GAP_W'(T_MRD);
    if (s == S_EMR2) begin
      cmd_o.code = CMD_EMRS;
      cmd_o.bank = 2'd2;
    end else if (s == S_EMR3) begin
      cmd_o.code = CMD_EMRS;
      cmd_o.bank = 2'd3;
    end else if (s == S_EMR1_ON || s == S_EMR1_X) begin
      cmd_o.code = CMD_EMRS;
      cmd_o.bank = 2'd1;
      cmd_o.addr = emr1_w;
    end else if (s == S_MR_RST) begin
      cmd_o.code    = CMD_MRS;
      cmd_o.addr    = mr_w;
      cmd_o.addr[8] = 1'b1;
    end else if (s == S_PREA) begin
      cmd_o.code     = CMD_PREA;
      cmd_o.addr[10] = 1'b1;
      gap_o          = GAP_W'(T_RP);
    end else if (s >= S_REF0 && s < S_MR_RUN) begin
      cmd_o.code = CMD_REF;
      gap_o      = GAP_W'(T_RFC);
    end else if (s == S_MR_RUN) begin
      cmd_o.code = CMD_MRS;
      cmd_o.addr = mr_w;
      gap_o      = GAP_W'(T_OCD);
    end
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int N_REF = 2,
  parameter int T_MRD = 2,
  parameter int T_RP  = 3,
  parameter int T_RFC = 14,
  parameter int T_OCD = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        burst_len_i,
  input  logic [2:0]        cas_lat_i,
  input  logic [2:0]        wr_rec_i,
  input  logic [2:0]        add_lat_i,
  output logic [2:0]        cmd_o,
  output logic [1:0]        bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  localparam int N_STEPS = 7 + N_REF;
  localparam int STEP_W  = $clog2(N_STEPS + 1);
  localparam int GAP_MAX = max_of4(T_MRD, T_RP, T_RFC, T_OCD);
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  seq_st_e           st_q, st_d;
  logic [STEP_W-1:0] step_q;
  logic              gap_zero;
  logic              issue, finish;
  cmd_t              dec_cmd, cmd_q;
  logic [GAP_W-1:0]  dec_gap;
  logic              done_q;

  ddr2_init_step_dec #(
    .N_REF(N_REF), .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC), .T_OCD(T_OCD),
    .STEP_W(STEP_W), .GAP_W(GAP_W)
  ) dec_i (
    .step_i     (step_q),
    .burst_len_i(burst_len_i),
    .cas_lat_i  (cas_lat_i),
    .wr_rec_i   (wr_rec_i),
    .add_lat_i  (add_lat_i),
    .cmd_o      (dec_cmd),
    .gap_o      (dec_gap)
  );

  ddr2_init_gap_timer #(.GAP_W(GAP_W)) gap_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(issue),
    .val_i (dec_gap),
    .zero_o(gap_zero)
  );

  always_comb begin
    issue  = 1'b0;
    finish = 1'b0;
    st_d   = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        issue = 1'b1;
        st_d  = ST_RUN;
      end
      ST_RUN: if (gap_zero) begin
        if (step_q == STEP_W'(N_STEPS)) begin
          finish = 1'b1;
          st_d   = ST_DONE;
        end else begin
          issue = 1'b1;
        end
      end
      default: ;  // ST_DONE holds until reset
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      step_q <= '0;
      cmd_q  <= '{code: CMD_NOP, bank: 2'd0, addr: '0};
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_q | finish;
      if (issue) begin
        step_q <= step_q + STEP_W'(1);
        cmd_q  <= dec_cmd;
      end else begin
        cmd_q  <= '{code: CMD_NOP, bank: 2'd0, addr: '0};
      end
    end
  end

  assign cmd_o  = cmd_q.code;
  assign bank_o = cmd_q.bank;
  assign addr_o = cmd_q.addr;
  assign done_o = done_q;

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk
  import ddr2_init_pkg::*;
#(
  parameter int T_MRD = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        cmd_o,
  input logic [1:0]        bank_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o
);

  logic [7:0] since_q;

  // cycles since the last command, 0 = none yet, saturates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 since_q <= '0;
    else if (cmd_o != CMD_NOP)                   since_q <= 8'd1;
    else if (since_q != '0 && since_q != 8'hff)  since_q <= since_q + 8'd1;
  end

  p_one_cycle_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_NOP) |=> (cmd_o == CMD_NOP));

  p_min_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_NOP && since_q != '0) |-> (since_q >= 8'(T_MRD)));

  p_quiet_after_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cmd_o == CMD_NOP));

  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  p_emrs_target_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_EMRS) |-> (bank_o != 2'd0));

  p_emr1_fields_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_EMRS && bank_o == 2'd1) |->
      (addr_o[0] == 1'b0 && addr_o[10] && addr_o[9:7] == 3'd0 && addr_o[11] == 1'b0));

  p_mrs_fixed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_MRS) |-> (bank_o == 2'd0 && addr_o[3] == 1'b0 && addr_o[7] == 1'b0));

  p_prea_word_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PREA) |-> (addr_o == 14'h0400 && bank_o == 2'd0));

  p_ref_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_REF) |-> (addr_o == '0 && bank_o == 2'd0));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.T_MRD(T_MRD)) chk_i (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cmd_o (cmd_o),
  .bank_o(bank_o),
  .addr_o(addr_o),
  .done_o(done_o)
);

// File: tb/ddr2_init_seq_tb_top.sv
module ddr2_init_seq_tb_top;

  localparam int N_REF   = 3;
  localparam int T_MRD   = 2;
  localparam int T_RP    = 3;
  localparam int T_RFC   = 14;
  localparam int T_OCD   = 200;
  localparam int N_STEPS = 7 + N_REF;
  localparam int MAX_REC = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  bl = '0, cl = '0, wr = '0, al = '0;
  logic [2:0]  cmd;
  logic [1:0]  bank;
  logic [13:0] addr;
  logic        done;

  int checks = 0;
  int errors = 0;
  int wd = 0;

  int rec_cmd [MAX_REC];
  int rec_bank[MAX_REC];
  int rec_addr[MAX_REC];
  int rec_cyc [MAX_REC];
  int n_rec;
  int done_cyc;

  always #2 clk = ~clk;

  ddr2_init_seq #(
    .N_REF(N_REF), .T_MRD(T_MRD), .T_RP(T_RP), .T_RFC(T_RFC), .T_OCD(T_OCD)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .burst_len_i(bl), .cas_lat_i(cl), .wr_rec_i(wr), .add_lat_i(al),
    .cmd_o(cmd), .bank_o(bank), .addr_o(addr), .done_o(done)
  );

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual=%0d expected<=%0d", wd, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // expected stream from the requirements
  function automatic int e_cmd(int k);
    if (k <= 2) return 2;
    if (k == 3) return 1;
    if (k == 4) return 3;
    if (k < 5 + N_REF) return 4;
    if (k == 5 + N_REF) return 1;
    return 2;
  endfunction

  function automatic int e_bank(int k);
    if (k == 0) return 2;
    if (k == 1) return 3;
    if (k == 2 || k == 6 + N_REF) return 1;
    return 0;
  endfunction

  function automatic int e_addr(int k);
    int emr1, mr;
    emr1 = (int'(al) << 3) | (1 << 10);
    mr   = int'(bl) | (int'(cl) << 4) | (int'(wr) << 9);
    if (k == 2 || k == 6 + N_REF) return emr1;
    if (k == 3) return mr | (1 << 8);
    if (k == 4) return 1 << 10;
    if (k == 5 + N_REF) return mr;
    return 0;
  endfunction

  function automatic int e_gap(int k);
    if (k == 4) return T_RP;
    if (k >= 5 && k < 5 + N_REF) return T_RFC;
    if (k == 5 + N_REF) return T_OCD;
    return T_MRD;
  endfunction

  function automatic string req_of(int k);
    if (k == 0 || k == 1) return "R3";
    if (k == 2 || k == 6 + N_REF) return "R4";
    if (k == 3 || k == 5 + N_REF) return "R5";
    if (k == 4) return "R6";
    return "R7";
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // R1: idle outputs after reset, start absent
  task automatic t_reset_state();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 0 || i == 9) begin
        chk("R1", "idle cmd", int'(cmd), 0);
        chk("R1", "idle bank", int'(bank), 0);
        chk("R1", "idle addr", int'(addr), 0);
        chk("R1", "idle done", int'(done), 0);
      end
    end
  endtask

  // full run; g1/g2 are cycles at which a stray start pulse is applied (R10)
  task automatic t_sequence(string name, logic [2:0] b, logic [2:0] c,
                            logic [2:0] w, logic [2:0] a, int g1, int g2);
    int cyc;
    int exp_cyc;
    bl = b; cl = c; wr = w; al = a;
    n_rec    = 0;
    done_cyc = -1;
    @(negedge clk);
    start = 1'b1;
    for (int i = 1; i < 1000; i++) begin
      @(negedge clk);
      cyc = i;
      start = (cyc == g1 || cyc == g2);
      if (cmd != 3'd0 && n_rec < MAX_REC) begin
        rec_cmd[n_rec]  = int'(cmd);
        rec_bank[n_rec] = int'(bank);
        rec_addr[n_rec] = int'(addr);
        rec_cyc[n_rec]  = cyc;
        n_rec++;
      end
      if (done && done_cyc < 0) done_cyc = cyc;
      if (done_cyc >= 0) break;
    end
    start = 1'b0;
    $display("  scenario %s: %0d commands", name, n_rec);
    chk("R2", {name, " command count"}, n_rec, N_STEPS);
    exp_cyc = 1;  // R11: first command one cycle after start is sampled
    for (int k = 0; k < N_STEPS && k < n_rec; k++) begin
      chk("R2", $sformatf("%s step %0d code", name, k), rec_cmd[k], e_cmd(k));
      chk(req_of(k), $sformatf("%s step %0d bank", name, k), rec_bank[k], e_bank(k));
      chk(req_of(k), $sformatf("%s step %0d addr", name, k), rec_addr[k], e_addr(k));
      chk(k == 0 ? "R11" : "R8", $sformatf("%s step %0d cycle", name, k), rec_cyc[k], exp_cyc);
      exp_cyc += e_gap(k);
    end
    chk("R9", {name, " done cycle"}, done_cyc, exp_cyc - e_gap(N_STEPS - 1) + T_MRD);
  endtask

  // R9/R10: after done, start is ignored and done stays high
  task automatic t_after_done();
    int seen;
    int low;
    seen = 0;
    low  = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (cmd != 3'd0) seen++;
      if (!done) low++;
      start = (i == 5 || i == 6);
    end
    start = 1'b0;
    chk("R10", "commands after done with start", seen, 0);
    chk("R9", "cycles with done low after completion", low, 0);
  endtask

  // R1: reset aborts a running sequence
  task automatic t_mid_reset();
    bl = 3'd2; cl = 3'd3; wr = 3'd1; al = 3'd0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "async reset cmd", int'(cmd), 0);
    chk("R1", "async reset done", int'(done), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_sequence("A", 3'd2, 3'd3, 3'd2, 3'd0, 0, 0);
    t_after_done();
    do_reset();
    t_sequence("B", 3'd3, 3'd5, 3'd5, 3'd2, 8, 80);
    t_mid_reset();
    t_sequence("C", 3'd2, 3'd4, 3'd3, 3'd4, 2, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule